// File: doc/BRIEF.md
# Quadrature Counter with Selectable Flag Interrupt

This block is one channel of an up/down position counter for an incremental encoder. It brings the two phase inputs and the index input through a two-flop synchronizer. It then turns legal phase transitions into count steps at one, two or four steps per encoder cycle. The steps drive a 25-bit wrapping count. The count is compared with a preset value, and the block watches for wrap past the top (carry) and wrap below zero (borrow).

One of four flag sources is picked by a mode field: carry, preset match, carry-or-borrow, or index level. The picked source drives a flag pin, and its events set a sticky status bit. A global enable gates the status bit into the interrupt line. Software reaches everything through a small write/read register port. It can load the count or the preset, reset the count, choose scaling and flag source, enable interrupts, and clear the status bit by writing a one to it.

Top module: `qcnt_flag_irq`

## Requirements
- R1: With scale field mode[1:0]=2 (x4), every legal single phase step changes the count by one. The phase order {A,B} 00,10,11,01,00 counts up, and the reverse order counts down.
- R2: With mode[1:0]=1 (x2), only steps in which A changes move the count, up or down by the same direction rule. Steps in which only B changes leave the count unchanged.
- R3: With mode[1:0]=0 (x1), the count rises only on the step 00 to 10 and falls only on the step 10 to 00. All other steps leave it unchanged.
- R4: A transition in which A and B both change at once leaves the count unchanged.
- R5: Counting up from 2^25-1 gives 0 and a carry event. Counting down from 0 gives 2^25-1 and a borrow event.
- R6: A write to address 0 loads the count from wdata[23:0] with count bit 24 cleared. A write to address 2 with wdata[0]=1 resets the count to 0.
- R7: With flag source mode[4:2]=1 (carry), the flag pin shows a carry toggle that starts at 1 and inverts on every carry. Each carry sets the status bit.
- R8: With mode[4:2]=3 (carry-or-borrow), the flag pin is the AND of the carry and borrow toggles. The borrow toggle starts at 1 and inverts on every borrow. Either event sets the status bit.
- R9: With mode[4:2]=2 (match), the match toggle inverts and the status bit sets only in the cycle the count becomes equal to the preset (address 1, 24 bits). A count that stays equal does not set the status bit again.
- R10: With mode[4:2]=4 (index), the flag pin follows the synchronized index input, and the status bit sets while the index is high. The status bit stays set after the index falls.
- R11: With mode[4:2] set to 0, 5, 6 or 7, the flag pin is 1 and no event sets the status bit.
- R12: The status bit sets only while the enable bit (address 2, wdata[2]) is 1. The irq pin is the status bit ANDed with the enable bit.
- R13: A write to address 4 with wdata[0]=1 clears the status bit, which reads back at address 4 bit 0.
- R14: After reset, the count, preset, enable, mode and status are all 0. The irq pin is 0 and the flag pin is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder index, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 count, 1 preset, 2 control, 3 mode, 4 status) |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr, combinational |
| flag_o | output | 1 | Selected flag output |
| irq_o | output | 1 | Interrupt request |

## Verification
Each scaling mode is driven with a full forward walk of sixteen phase steps and then a full reverse walk. The count is compared after every step, which shows which step kinds each scale counts and in which direction. A jump in which both phases change is driven from rest and back, which separates an ignored illegal step from a miscounted one. The wrap events are reached by stepping down from zero and back up. That setup tells carry from borrow in each flag source, and it also tells a gated event from an ungated one. A match is entered, held and re-entered, which separates edge-triggered setting from level-triggered setting. The index is raised under the index source and under unused source codes.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;
  typedef enum logic [2:0] {
    FS_NONE  = 3'd0,
    FS_CARRY = 3'd1,
    FS_CMP   = 3'd2,
    FS_CB    = 3'd3,
    FS_INDEX = 3'd4
  } flag_sel_e;

  typedef enum logic [1:0] {
    SC_X1 = 2'd0,
    SC_X2 = 2'd1,
    SC_X4 = 2'd2
  } scale_e;

  localparam logic [2:0] A_COUNT  = 3'd0;
  localparam logic [2:0] A_PRESET = 3'd1;
  localparam logic [2:0] A_CTRL   = 3'd2;
  localparam logic [2:0] A_MODE   = 3'd3;
  localparam logic [2:0] A_STAT   = 3'd4;
endpackage

// File: rtl/qcnt_decode.sv
module qcnt_decode
  import qcnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       idx_i,
  input  logic [1:0] scale_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       idx_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [2:0] sync_q [SYNC_STAGES];
  logic [1:0] ab_q;
  logic [1:0] ab_now;
  logic [1:0] pos_now, pos_prev, step;
  logic       a_chg, fwd, bwd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      ab_q <= '0;
    end else begin
      sync_q[0] <= {idx_i, a_i, b_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      ab_q <= ab_now;
    end
  end

  assign ab_now = sync_q[LAST][1:0];
  assign idx_o  = sync_q[LAST][2];

  // Phase position: 00->0, 10->1, 11->2, 01->3
  assign pos_now  = {ab_now[0], ab_now[1] ^ ab_now[0]};
  assign pos_prev = {ab_q[0],   ab_q[1]   ^ ab_q[0]};
  assign step     = pos_now - pos_prev;
  assign a_chg    = ab_now[1] ^ ab_q[1];
  assign fwd      = (step == 2'd1);
  assign bwd      = (step == 2'd3);

  always_comb begin
    unique case (scale_i)
      SC_X1: begin
        up_o = fwd && (pos_prev == 2'd0);
        dn_o = bwd && (pos_prev == 2'd1);
      end
      SC_X2: begin
        up_o = fwd && a_chg;
        dn_o = bwd && a_chg;
      end
      default: begin
        up_o = fwd;
        dn_o = bwd;
      end
    endcase
  end

  assert_illegal_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ab_now[1] != ab_q[1]) && (ab_now[0] != ab_q[0])) |-> !(up_o || dn_o));
  assert_one_direction_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({up_o, dn_o}));
endmodule

// File: rtl/qcnt_core.sv
module qcnt_core #(
  parameter int CNT_W = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_i,
  input  logic               dn_i,
  input  logic               clr_i,
  input  logic               ld_i,
  input  logic [CNT_W-2:0]   ld_val_i,
  input  logic [CNT_W-2:0]   preset_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               carry_o,
  output logic               borrow_o,
  output logic               match_o
);
  localparam int LOAD_W = CNT_W - 1;
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q, count_d;
  logic             eq_q, eq_now, moving;

  assign moving   = !clr_i && !ld_i;
  assign carry_o  = moving && up_i && (count_q == MAX);
  assign borrow_o = moving && dn_i && (count_q == '0);
  assign eq_now   = (count_q == {1'b0, preset_i});
  assign match_o  = eq_now && !eq_q;

  always_comb begin
    count_d = count_q;
    if (clr_i)     count_d = '0;
    else if (ld_i) count_d = {1'b0, ld_val_i[LOAD_W-1:0]};
    else if (up_i) count_d = count_q + 1'b1;
    else if (dn_i) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      eq_q    <= 1'b1;
    end else begin
      count_q <= count_d;
      eq_q    <= eq_now;
    end
  end

  assign count_o = count_q;

  assert_carry_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_i && moving && (count_q == MAX)) |=> (count_q == '0));
  assert_borrow_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_i && !up_i && moving && (count_q == '0)) |=> (count_q == MAX));
  assert_load_top_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && !clr_i) |=> !count_q[CNT_W-1]);
endmodule

// File: rtl/qcnt_flag.sv
module qcnt_flag
  import qcnt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       carry_i,
  input  logic       borrow_i,
  input  logic       match_i,
  input  logic       idx_i,
  input  logic [2:0] sel_i,
  input  logic       en_i,
  input  logic       clr_i,
  output logic       flag_o,
  output logic       status_o,
  output logic       irq_o
);
  logic carry_t_q, borrow_t_q, match_t_q, status_q;
  logic carry_t_d, borrow_t_d, match_t_d, status_d;
  logic set_now;

  always_comb begin
    carry_t_d  = carry_t_q  ^ carry_i;
    borrow_t_d = borrow_t_q ^ borrow_i;
    match_t_d  = match_t_q  ^ match_i;
    case (sel_i)
      FS_CARRY: begin set_now = carry_i;             flag_o = carry_t_q; end
      FS_CMP:   begin set_now = match_i;             flag_o = match_t_q; end
      FS_CB:    begin set_now = carry_i || borrow_i; flag_o = carry_t_q && borrow_t_q; end
      FS_INDEX: begin set_now = idx_i;               flag_o = idx_i; end
      default:  begin set_now = 1'b0;                flag_o = 1'b1; end
    endcase
    status_d = (status_q && !clr_i) || (set_now && en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_t_q  <= 1'b1;
      borrow_t_q <= 1'b1;
      match_t_q  <= 1'b1;
      status_q   <= 1'b0;
    end else begin
      carry_t_q  <= carry_t_d;
      borrow_t_q <= borrow_t_d;
      match_t_q  <= match_t_d;
      status_q   <= status_d;
    end
  end

  assign status_o = status_q;
  assign irq_o    = status_q && en_i;

  assert_enable_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(en_i));
  assert_w1c_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(set_now && en_i)) |=> !status_q);
  assert_match_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == FS_CMP && match_i && en_i) |=> status_q);
  assert_unused_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == FS_NONE || sel_i > FS_INDEX) |=> !$rose(status_q));
endmodule

// File: rtl/qcnt_flag_irq.sv
module qcnt_flag_irq
  import qcnt_pkg::*;
#(
  parameter int CNT_W       = 25,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_idx,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              flag_o,
  output logic              irq_o
);
  localparam int LOAD_W = CNT_W - 1;
  localparam int MODE_W = 5;

  logic [1:0]        rst_pipe;
  logic              rst_i_n;
  logic [LOAD_W-1:0] preset_q, preset_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              en_q, en_d;
  logic              wr_cnt, wr_pre, wr_ctrl, wr_mode, wr_stat;
  logic              up, dn, idx_s, carry, borrow, match, status;
  logic [CNT_W-1:0]  count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  assign wr_cnt  = wr_en && (addr == A_COUNT);
  assign wr_pre  = wr_en && (addr == A_PRESET);
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_mode = wr_en && (addr == A_MODE);
  assign wr_stat = wr_en && (addr == A_STAT);

  always_comb begin
    preset_d = wr_pre  ? wdata[LOAD_W-1:0] : preset_q;
    mode_d   = wr_mode ? wdata[MODE_W-1:0] : mode_q;
    en_d     = wr_ctrl ? wdata[2]          : en_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      preset_q <= '0;
      mode_q   <= '0;
      en_q     <= 1'b0;
    end else begin
      preset_q <= preset_d;
      mode_q   <= mode_d;
      en_q     <= en_d;
    end
  end

  qcnt_decode #(.SYNC_STAGES(SYNC_STAGES)) u_decode (
    .clk(clk), .rst_n(rst_i_n), .a_i(enc_a), .b_i(enc_b), .idx_i(enc_idx),
    .scale_i(mode_q[1:0]), .up_o(up), .dn_o(dn), .idx_o(idx_s)
  );

  qcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_i_n), .up_i(up), .dn_i(dn),
    .clr_i(wr_ctrl && wdata[0]), .ld_i(wr_cnt), .ld_val_i(wdata[LOAD_W-1:0]),
    .preset_i(preset_q), .count_o(count), .carry_o(carry),
    .borrow_o(borrow), .match_o(match)
  );

  qcnt_flag u_flag (
    .clk(clk), .rst_n(rst_i_n), .carry_i(carry), .borrow_i(borrow),
    .match_i(match), .idx_i(idx_s), .sel_i(mode_q[4:2]), .en_i(en_q),
    .clr_i(wr_stat && wdata[0]), .flag_o(flag_o), .status_o(status),
    .irq_o(irq_o)
  );

  always_comb begin
    rd_data = '0;
    case (addr)
      A_COUNT:  rd_data[CNT_W-1:0]  = count;
      A_PRESET: rd_data[LOAD_W-1:0] = preset_q;
      A_CTRL:   rd_data[2]          = en_q;
      A_MODE:   rd_data[MODE_W-1:0] = mode_q;
      A_STAT:   rd_data[0]          = status;
      default:  rd_data             = '0;
    endcase
  end

  assert_irq_needs_enable_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(irq_o) |-> en_q);
endmodule

// File: tb/qcnt_flag_irq_bench.sv
module qcnt_flag_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        flag_o, irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int pos = 0;
  int scale_b = 0;
  longint cnt_exp = 0;
  localparam longint MOD = 64'd33554432;

  always #5 clk = ~clk;

  qcnt_flag_irq u_qcnt_flag_irq (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output longint v);
    addr = a;
    #1;
    v = longint'(rd_data);
  endtask

  function automatic bit pa(input int p); return (p == 1) || (p == 2); endfunction
  function automatic bit pb(input int p); return (p == 2) || (p == 3); endfunction

  // Expected step from the scaling rules of R1, R2, R3 and R4
  function automatic int delta(input int from, input int to, input int sc);
    int d = (to - from + 4) % 4;
    if (d == 1) begin
      if (sc == 2) return 1;
      if (sc == 1) return (pa(from) != pa(to)) ? 1 : 0;
      return (from == 0) ? 1 : 0;
    end
    if (d == 3) begin
      if (sc == 2) return -1;
      if (sc == 1) return (pa(from) != pa(to)) ? -1 : 0;
      return (from == 1) ? -1 : 0;
    end
    return 0;
  endfunction

  task automatic step(input int np);
    @(negedge clk);
    enc_a = pa(np); enc_b = pb(np);
    repeat (6) @(negedge clk);
    cnt_exp = (cnt_exp + delta(pos, np, scale_b) + MOD) % MOD;
    pos = np;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint v;
    longint f0;
    string tag;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R14 reset state
    rd(3'd0, v); chk("R14 count", v, 0);
    rd(3'd1, v); chk("R14 preset", v, 0);
    rd(3'd2, v); chk("R14 enable", v, 0);
    rd(3'd3, v); chk("R14 mode", v, 0);
    rd(3'd4, v); chk("R14 status", v, 0);
    chk("R14 irq", irq_o, 0);
    chk("R14 flag", flag_o, 1);

    // R1/R2/R3 sweeps: forward and reverse walks per scale
    for (int sc = 0; sc < 3; sc++) begin
      scale_b = sc;
      tag = (sc == 2) ? "R1" : (sc == 1) ? "R2" : "R3";
      wr(3'd3, 32'(sc));
      wr(3'd2, 32'h1);
      cnt_exp = 0;
      rd(3'd0, v); chk("R6 reset command", v, 0);
      for (int k = 0; k < 16; k++) begin
        step((pos + 1) % 4);
        rd(3'd0, v); chk(tag, v, cnt_exp);
      end
      for (int k = 0; k < 16; k++) begin
        step((pos + 3) % 4);
        rd(3'd0, v); chk(tag, v, cnt_exp);
      end
    end

    // R4 illegal double change
    scale_b = 2;
    wr(3'd3, 32'd2);
    rd(3'd0, v); f0 = v;
    step((pos + 2) % 4);
    rd(3'd0, v); chk("R4 jump out", v, f0);
    step((pos + 2) % 4);
    rd(3'd0, v); chk("R4 jump back", v, f0);

    // R6 load and reset command
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R6 load 24 bits", v, 64'hFF_FFFF);
    wr(3'd2, 32'h1);
    cnt_exp = 0;
    rd(3'd0, v); chk("R6 reset command", v, 0);

    // R5/R8 borrow under carry-or-borrow source
    wr(3'd2, 32'h4);
    wr(3'd3, 32'd14);
    wr(3'd4, 32'h1);
    step((pos + 3) % 4);
    rd(3'd0, v); chk("R5 borrow wrap", v, MOD - 1);
    rd(3'd4, v); chk("R8 status on borrow", v, 1);
    chk("R12 irq", irq_o, 1);
    chk("R8 flag", flag_o, 0);

    // R5/R7 carry under carry source
    wr(3'd4, 32'h1);
    rd(3'd4, v); chk("R13 cleared", v, 0);
    chk("R13 irq low", irq_o, 0);
    wr(3'd3, 32'd6);
    chk("R7 flag idle", flag_o, 1);
    step((pos + 1) % 4);
    rd(3'd0, v); chk("R5 carry wrap", v, 0);
    rd(3'd4, v); chk("R7 status on carry", v, 1);
    chk("R7 flag toggled", flag_o, 0);
    wr(3'd4, 32'h1);
    rd(3'd4, v); chk("R13 cleared", v, 0);

    // R9 match: enter, hold, re-enter
    wr(3'd1, 32'd5);
    wr(3'd3, 32'd10);
    wr(3'd0, 32'd3);
    cnt_exp = 3;
    wr(3'd4, 32'h1);
    f0 = longint'(flag_o);
    step((pos + 1) % 4);
    step((pos + 1) % 4);
    rd(3'd0, v); chk("R9 count at preset", v, 5);
    rd(3'd4, v); chk("R9 status on match", v, 1);
    chk("R9 flag toggled", flag_o, 1 - f0);
    wr(3'd4, 32'h1);
    idle(6);
    rd(3'd4, v); chk("R9 hold no retrigger", v, 0);
    step((pos + 1) % 4);
    step((pos + 3) % 4);
    rd(3'd4, v); chk("R9 re-entry sets", v, 1);
    chk("R9 flag toggled back", flag_o, f0);

    // R10 index source
    wr(3'd3, 32'd18);
    wr(3'd4, 32'h1);
    enc_idx = 1'b1; idle(6);
    chk("R10 flag high", flag_o, 1);
    rd(3'd4, v); chk("R10 status set", v, 1);
    enc_idx = 1'b0; idle(6);
    chk("R10 flag low", flag_o, 0);
    rd(3'd4, v); chk("R10 status sticky", v, 1);
    wr(3'd4, 32'h1);
    rd(3'd4, v); chk("R13 cleared", v, 0);

    // R11 unused source codes
    wr(3'd3, 32'd2);
    chk("R11 flag code 0", flag_o, 1);
    wr(3'd3, 32'd22);
    enc_idx = 1'b1; idle(6);
    rd(3'd4, v); chk("R11 index ignored code 5", v, 0);
    chk("R11 flag code 5", flag_o, 1);
    enc_idx = 1'b0; idle(4);
    wr(3'd3, 32'd2);
    wr(3'd0, 32'd0);
    cnt_exp = 0;
    step((pos + 3) % 4);
    rd(3'd0, v); chk("R5 borrow wrap", v, MOD - 1);
    rd(3'd4, v); chk("R11 borrow ignored", v, 0);
    step((pos + 1) % 4);

    // R12 enable gate
    wr(3'd2, 32'h0);
    wr(3'd3, 32'd14);
    step((pos + 3) % 4);
    rd(3'd4, v); chk("R12 gated status", v, 0);
    chk("R12 gated irq", irq_o, 0);
    wr(3'd2, 32'h4);
    rd(3'd4, v); chk("R12 no stale status", v, 0);
    chk("R12 no stale irq", irq_o, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule